// File: doc/BRIEF.md
# Dual-Bank SDRAM Command Decoder

This block sits at the command pins of a two-bank synchronous DRAM model or controller front end. On every rising clock edge it samples the chip-select, row-strobe, column-strobe, write-enable, clock-enable, eleven address lines and the bank-select line. It turns the strobe levels into one registered command pulse: activate, read, write, precharge, auto refresh or mode-register set. Alongside the pulse it presents the row address, column address, target bank and auto-precharge flag.

For each of the two banks it tracks whether the bank is idle or holds an open row, and which row that is. A read or write with the top address line high schedules a precharge of that bank once a parameterised burst has run out. Commands that break the bank state rules raise a one-cycle error pulse instead of a command pulse. The column width follows the device organisation (x4, x8 or x16), which is set by a parameter.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: Inputs are sampled on the rising edge. A legal command decoded at edge N shows as a one-cycle pulse on exactly one of act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, visible after edge N. The strobe levels {ras_n,cas_n,we_n} map as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set. Both 111 and 110 give no pulse.
- R2: While cs_n is sampled high, no command pulse and no error pulse is produced. An auto-precharge countdown already running keeps counting.
- R3: While cke is sampled low, no command is decoded and any auto-precharge countdown is frozen.
- R4: A legal activate marks bank ba active and stores addr as its open row. The row is shown on row_o and on open_row_o, bank 0 in bits [10:0] and bank 1 in bits [21:11]. ba low selects bank 0 (A) and ba high selects bank 1 (B).
- R5: On read or write, col_o carries addr[COL_W-1:0] and bank_o carries ba. COL_W is 10, 9 or 8 for ORG_WIDTH 4, 8 or 16.
- R6: A legal read or write with addr[10] high sets auto_pre_o with the pulse. The addressed bank then reads idle on bank_active_o exactly BURST_LEN enabled edges later.
- R7: A precharge with addr[10] high idles both banks and sets pre_all_o. With addr[10] low it idles only bank ba. It also cancels a pending auto-precharge.
- R8: A read or write to an idle bank, or to a bank with a pending auto-precharge, or an activate to an active bank, gives an illegal_o pulse in place of the command pulse and leaves the bank state unchanged.
- R9: While rst is high, all pulses clear and both banks read idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable, low gates decoding |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Row / column address; bit 10 auto-precharge or all-bank flag |
| ba | input | 1 | Bank select |
| act_o | output | 1 | Activate pulse |
| rd_o | output | 1 | Read pulse |
| wr_o | output | 1 | Write pulse |
| pre_o | output | 1 | Precharge pulse |
| ref_o | output | 1 | Auto refresh pulse |
| mrs_o | output | 1 | Mode-register set pulse |
| illegal_o | output | 1 | Illegal command pulse |
| row_o | output | 11 | Row of the last activate |
| col_o | output | COL_W | Column of the last read or write |
| bank_o | output | 1 | Bank of the last decoded command |
| auto_pre_o | output | 1 | Read or write requested auto-precharge |
| pre_all_o | output | 1 | Precharge covered both banks |
| bank_active_o | output | 2 | Per-bank active flag |
| open_row_o | output | 22 | Open row of each bank |

## Verification
The hardest situation to reach is a pending auto-precharge whose countdown is disturbed. One case is cke going low partway through the countdown. The others are cs_n rising, or a second access arriving at the busy bank, before the countdown ends. The stimulus issues a read with auto-precharge and then holds cke low or cs_n high for several edges before returning to no-operation. It counts the edges until bank_active_o drops. A separate run sends a read to the still-busy bank during its countdown and expects an error pulse with the bank state left as it was.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_t;

  function automatic int col_width(input int org);
    case (org)
      16:      return 8;
      8:       return 9;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_t cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W     = 11,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             act_hit,
  input  logic             ap_hit,
  input  logic             pre_hit,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic             busy,
  output logic [ROW_W-1:0] row
);

  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      row    <= '0;
    end else if (pre_hit) begin
      active <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
    end else if (act_hit) begin
      active <= 1'b1;
      row    <= row_in;
    end else if (ap_hit) begin
      busy <= 1'b1;
      cnt  <= CNT_LOAD;
    end else if (busy && tick) begin
      if (cnt == '0) begin
        active <= 1'b0;
        busy   <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int ORG_WIDTH = 4,
  parameter int ADDR_W    = 11,
  parameter int BURST_LEN = 4,
  parameter int COL_W     = col_width(ORG_WIDTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  ba,
  output logic                  act_o,
  output logic                  rd_o,
  output logic                  wr_o,
  output logic                  pre_o,
  output logic                  ref_o,
  output logic                  mrs_o,
  output logic                  illegal_o,
  output logic [ADDR_W-1:0]     row_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  bank_o,
  output logic                  auto_pre_o,
  output logic                  pre_all_o,
  output logic [1:0]            bank_active_o,
  output logic [2*ADDR_W-1:0]   open_row_o
);

  localparam int NUM_BANKS = 2;
  localparam int FLAG_BIT  = ADDR_W - 1;

  cmd_t cmd;
  logic [NUM_BANKS-1:0] b_active, b_busy, act_hit, ap_hit, pre_hit;
  logic sel_active, sel_busy, is_access, bad, ok;

  sdram_cmd_decode u_decode (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign sel_active = b_active[ba];
  assign sel_busy   = b_busy[ba];
  assign is_access  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign bad        = ((cmd == CMD_ACT) && sel_active) ||
                      (is_access && (!sel_active || sel_busy));
  assign ok         = !bad;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit        = (ba == 1'(b));
    assign act_hit[b] = (cmd == CMD_ACT) && ok && hit;
    assign ap_hit[b]  = is_access && ok && hit && addr[FLAG_BIT];
    assign pre_hit[b] = (cmd == CMD_PRE) && (addr[FLAG_BIT] || hit);

    sdram_bank_slot #(
      .ROW_W     (ADDR_W),
      .BURST_LEN (BURST_LEN)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .tick    (cke),
      .act_hit (act_hit[b]),
      .ap_hit  (ap_hit[b]),
      .pre_hit (pre_hit[b]),
      .row_in  (addr),
      .active  (b_active[b]),
      .busy    (b_busy[b]),
      .row     (open_row_o[b*ADDR_W +: ADDR_W])
    );
  end

  assign bank_active_o = b_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o      <= 1'b0;
      rd_o       <= 1'b0;
      wr_o       <= 1'b0;
      pre_o      <= 1'b0;
      ref_o      <= 1'b0;
      mrs_o      <= 1'b0;
      illegal_o  <= 1'b0;
      row_o      <= '0;
      col_o      <= '0;
      bank_o     <= 1'b0;
      auto_pre_o <= 1'b0;
      pre_all_o  <= 1'b0;
    end else begin
      act_o     <= (cmd == CMD_ACT) && ok;
      rd_o      <= (cmd == CMD_RD) && ok;
      wr_o      <= (cmd == CMD_WR) && ok;
      pre_o     <= (cmd == CMD_PRE);
      ref_o     <= (cmd == CMD_REF);
      mrs_o     <= (cmd == CMD_MRS);
      illegal_o <= bad;
      if (cmd != CMD_NOP && ok) begin
        bank_o     <= ba;
        auto_pre_o <= is_access && addr[FLAG_BIT];
        pre_all_o  <= (cmd == CMD_PRE) && addr[FLAG_BIT];
        if (cmd == CMD_ACT) row_o <= addr;
        if (is_access)      col_o <= addr[COL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic       cs_n,
  input logic       act_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic       pre_o,
  input logic       ref_o,
  input logic       mrs_o,
  input logic       illegal_o,
  input logic       bank_o,
  input logic       auto_pre_o,
  input logic [1:0] bank_active_o
);

  logic [5:0] pulses;
  assign pulses = {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o};

  // R1
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulses));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (pulses == 6'b0));

  // R4
  act_marks_bank_chk: assert property (@(posedge clk) disable iff (rst)
    act_o |-> bank_active_o[bank_o]);

  // R3
  cke_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cke) |-> (pulses == 6'b0 && !illegal_o));

  // R2
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (pulses == 6'b0 && !illegal_o));

  // R6
  ap_with_access_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) && auto_pre_o |-> bank_active_o[bank_o]);

endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .cke           (cke),
  .cs_n          (cs_n),
  .act_o         (act_o),
  .rd_o          (rd_o),
  .wr_o          (wr_o),
  .pre_o         (pre_o),
  .ref_o         (ref_o),
  .mrs_o         (mrs_o),
  .illegal_o     (illegal_o),
  .bank_o        (bank_o),
  .auto_pre_o    (auto_pre_o),
  .bank_active_o (bank_active_o)
);

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic ba = 1'b0;
  logic act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o;
  logic [10:0] row_o;
  logic [COL_W-1:0] col_o;
  logic bank_o, auto_pre_o, pre_all_o;
  logic [1:0] bank_active_o;
  logic [21:0] open_row_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_ctrl u_dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
    .ref_o(ref_o), .mrs_o(mrs_o), .illegal_o(illegal_o),
    .row_o(row_o), .col_o(col_o), .bank_o(bank_o),
    .auto_pre_o(auto_pre_o), .pre_all_o(pre_all_o),
    .bank_active_o(bank_active_o), .open_row_o(open_row_o)
  );

  // vector: {cs_n,ras_n,cas_n,we_n}, ba, addr, {act,rd,wr,pre,ref,mrs,ill}, active
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {4'b0111, 1'b0, 11'h000, 7'b0000000, 2'b00}, // R1 nop
    {4'b0011, 1'b0, 11'h155, 7'b1000000, 2'b01}, // R1 R4 activate A
    {4'b0101, 1'b0, 11'h2AA, 7'b0100000, 2'b01}, // R1 read A
    {4'b0100, 1'b1, 11'h001, 7'b0000001, 2'b01}, // R8 write idle B
    {4'b0011, 1'b1, 11'h7FF, 7'b1000000, 2'b11}, // R4 activate B
    {4'b0011, 1'b0, 11'h010, 7'b0000001, 2'b11}, // R8 activate open A
    {4'b0010, 1'b1, 11'h000, 7'b0001000, 2'b01}, // R7 precharge B only
    {4'b1011, 1'b1, 11'h004, 7'b0000000, 2'b01}, // R2 deselected activate
    {4'b0001, 1'b0, 11'h000, 7'b0000100, 2'b01}, // R1 refresh
    {4'b0000, 1'b0, 11'h033, 7'b0000010, 2'b01}, // R1 mode set
    {4'b0010, 1'b1, 11'h400, 7'b0001000, 2'b00}, // R7 precharge all
    {4'b0011, 1'b1, 11'h005, 7'b1000000, 2'b10}  // R4 activate B row 5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] c, input logic b, input logic [10:0] a);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [6:0] strobes();
    return {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 reset", {23'b0, strobes(), bank_active_o}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i][24:21], VEC[i][20], VEC[i][19:9]);
      check($sformatf("R1 table[%0d]", i), {23'b0, strobes(), bank_active_o},
            {23'b0, VEC[i][8:0]});
    end

    // R4 row capture
    check("R4 row_o", row_o, 11'h005);
    check("R4 open row B", open_row_o[21:11], 11'h005);
    step(1'b1, 4'b0011, 1'b0, 11'h3C3);
    check("R4 open row A", open_row_o[10:0], 11'h3C3);
    check("R4 both active", bank_active_o, 2'b11);

    // R5 column and bank
    step(1'b1, 4'b0101, 1'b0, 11'h3FF);
    check("R5 col read", col_o, 10'h3FF);
    check("R5 no ap", {bank_o, auto_pre_o}, 2'b00);

    // R6 write with auto-precharge on B
    step(1'b1, 4'b0100, 1'b1, 11'h412);
    check("R6 write pulse", {wr_o, auto_pre_o, bank_o}, 3'b111);
    check("R5 col write", col_o, 10'h012);
    step(1'b1, 4'b0101, 1'b1, 11'h000);
    check("R8 read busy bank", {strobes(), bank_active_o}, {7'b0000001, 2'b11});
    step(1'b1, 4'b0111, 1'b0, 11'h000);
    check("R6 still active 2", bank_active_o, 2'b11);
    step(1'b1, 4'b0111, 1'b0, 11'h000);
    check("R6 still active 3", bank_active_o, 2'b11);
    step(1'b1, 4'b0111, 1'b0, 11'h000);
    check("R6 idle after burst", bank_active_o, 2'b01);

    // R3 clock enable low freezes countdown
    step(1'b1, 4'b0101, 1'b0, 11'h400);
    check("R6 read ap", {rd_o, auto_pre_o}, 2'b11);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 4'b0011, 1'b1, 11'h009);
      check("R3 gated", {strobes(), bank_active_o}, {7'b0, 2'b01});
    end
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 4'b0111, 1'b0, 11'h000);
      check("R3 frozen count", bank_active_o, 2'b01);
    end
    step(1'b1, 4'b0111, 1'b0, 11'h000);
    check("R3 R6 idle", bank_active_o, 2'b00);

    // R7 all-bank precharge
    step(1'b1, 4'b0011, 1'b0, 11'h001);
    step(1'b1, 4'b0011, 1'b1, 11'h002);
    check("R7 pre setup", bank_active_o, 2'b11);
    step(1'b1, 4'b0010, 1'b0, 11'h400);
    check("R7 all", {pre_o, pre_all_o, bank_active_o}, 4'b1100);

    // R2 countdown continues while deselected
    step(1'b1, 4'b0011, 1'b0, 11'h007);
    step(1'b1, 4'b0101, 1'b0, 11'h400);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 4'b1010, 1'b1, 11'h400);
      check("R2 deselected", {strobes(), bank_active_o}, {7'b0, 2'b01});
    end
    step(1'b1, 4'b1010, 1'b1, 11'h400);
    check("R2 idle after burst", bank_active_o, 2'b00);

    // R9 reset mid-operation
    step(1'b1, 4'b0011, 1'b0, 11'h001);
    rst = 1'b1;
    step(1'b1, 4'b0111, 1'b0, 11'h000);
    check("R9 reset clears", {strobes(), bank_active_o}, 9'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule